// File: doc/BRIEF.md
# Counter-Bit Transition Event Generator

This block turns a free-running 64-bit count into a sparse stream of wake-up pulses. It picks one of the sixteen lowest bits of the count. Each time that bit moves in the chosen direction, the block raises `evt_o` for one clock. Software sets the pulse period by choosing which bit to watch. Watching bit N gives one pulse every 2^(N+1) counts when the count steps by one. No divider value is loaded.

The watched count is selected by an input. It is either the physical count itself or a virtual count, which is the physical count minus an offset. A single control word holds three fields: an enable, a 4-bit bit index and a direction bit. It is written in one cycle. A write to the control word, or a change of the source, re-arms the history bit without raising a pulse. This makes reconfiguration glitch-free.

Top module: `evt_stream_gen`

## Requirements
- R1: While `rst_ni` is low and in the first cycle after reset, `evt_o` is 0, and generation starts disabled.
- R2: With the enable field (control bit 0) at 0, `evt_o` stays 0 whatever the count does.
- R3: With direction (control bit 5) at 0, a pulse is raised only when the watched bit goes from 0 to 1.
- R4: With direction at 1, a pulse is raised only when the watched bit goes from 1 to 0.
- R5: The bit index (control bits 4:1) selects the watched bit 0..15. With a count stepping by one, watching bit N yields one pulse every 2^(N+1) cycles.
- R6: With `src_virt_i` high, the watched count is `phys_cnt_i - virt_off_i`. With it low, the watched count is `phys_cnt_i`.
- R7: The cycle in which the control word is written never produces a pulse. The history bit is reloaded from the current count using the new index.
- R8: A cycle in which `src_virt_i` differs from its value in the previous cycle never produces a pulse. The history bit is reloaded from the new source.
- R9: Only a change of the watched bit between consecutive samples is detected. A jump that leaves the bit unchanged gives no pulse. At most one pulse occurs per cycle.
- R10: The pulse is registered. `evt_o` is high in the cycle after the clock edge that sampled the transition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| phys_cnt_i | input | 64 | Physical count |
| virt_off_i | input | 64 | Offset subtracted to form the virtual count |
| src_virt_i | input | 1 | 1 selects the virtual count, 0 selects the physical count |
| cfg_we_i | input | 1 | Control word write strobe |
| cfg_wdata_i | input | 6 | Control word: bit 0 enable, bits 4:1 bit index, bit 5 direction |
| evt_o | output | 1 | One-cycle event pulse |

## Verification
The embedded properties check the following on every cycle:
- a pulse only follows an enabled, non-write, non-switch cycle;
- the bit sampled before a pulse matches the configured direction;
- the history bit really differed from the current bit;
- the control word holds between writes.

The bench's reference model is needed for the remaining behaviours:
- the pulse period for a given index;
- the effect of the virtual offset;
- the suppression of pulses under large count jumps that skip over the watched bit.

It also confirms that no pulse is raised when the control word is written in the very cycle the watched bit would have fired.

// File: rtl/evt_pkg.sv
package evt_pkg;
  localparam int unsigned IDX_W = 4;
  localparam int unsigned CFG_W = IDX_W + 2;

  typedef struct packed {
    logic             dir;  // 0: rising, 1: falling
    logic [IDX_W-1:0] idx;
    logic             en;
  } evt_cfg_t;
endpackage

// File: rtl/evt_cfg_reg.sv
module evt_cfg_reg
  import evt_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [CFG_W-1:0] wdata_i,
  output evt_cfg_t         cfg_o,
  output logic             wr_o
);
  evt_cfg_t cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cfg_q <= '0;
    else if (we_i) cfg_q <= evt_cfg_t'(wdata_i);
  end

  assign cfg_o = cfg_q;
  assign wr_o  = we_i;

  p_cfg_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(cfg_q));
  p_cfg_load_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> cfg_q == $past(wdata_i));
endmodule

// File: rtl/evt_src_sel.sv
module evt_src_sel #(
  parameter int unsigned CNT_W    = 64,
  parameter bit          HAS_VIRT = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] phys_i,
  input  logic [CNT_W-1:0] off_i,
  input  logic             virt_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             chg_o
);
  logic src_q;

  generate
    if (HAS_VIRT) begin : g_virt
      logic [CNT_W-1:0] virt_cnt;
      assign virt_cnt = phys_i - off_i;
      assign cnt_o    = virt_i ? virt_cnt : phys_i;
    end else begin : g_phys
      assign cnt_o = phys_i;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) src_q <= 1'b0;
    else         src_q <= virt_i;
  end

  assign chg_o = virt_i ^ src_q;
endmodule

// File: rtl/evt_edge_det.sv
module evt_edge_det
  import evt_pkg::*;
#(
  parameter int unsigned CNT_W = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] cnt_i,
  input  evt_cfg_t         cfg_i,
  input  logic             wr_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic             src_chg_i,
  output logic             evt_o
);
  logic cur_bit, load_bit, prev_q, evt_q, hit;

  assign cur_bit  = cnt_i[cfg_i.idx];
  assign load_bit = cnt_i[wr_idx_i];

  // edge in configured direction: new bit must differ from dir
  assign hit = cfg_i.en & ~wr_i & ~src_chg_i & (prev_q ^ cur_bit) & (cur_bit ^ cfg_i.dir);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      evt_q  <= 1'b0;
    end else begin
      prev_q <= wr_i ? load_bit : cur_bit;
      evt_q  <= hit;
    end
  end

  assign evt_o = evt_q;

  p_en_gate_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_q |-> $past(cfg_i.en));
  p_rise_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_q && !$past(cfg_i.dir)) |-> $past(cur_bit));
  p_fall_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_q && $past(cfg_i.dir)) |-> !$past(cur_bit));
  p_quiet_write_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(wr_i) |-> !evt_q);
  p_quiet_switch_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(src_chg_i) |-> !evt_q);
  p_real_change_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_q |-> ($past(prev_q) != $past(cur_bit)));
endmodule

// File: rtl/evt_stream_gen.sv
module evt_stream_gen
  import evt_pkg::*;
#(
  parameter int unsigned CNT_W    = 64,
  parameter bit          HAS_VIRT = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] phys_cnt_i,
  input  logic [CNT_W-1:0] virt_off_i,
  input  logic             src_virt_i,
  input  logic             cfg_we_i,
  input  logic [CFG_W-1:0] cfg_wdata_i,
  output logic             evt_o
);
  evt_cfg_t         cfg;
  logic             wr;
  logic             src_chg;
  logic [CNT_W-1:0] cnt;
  evt_cfg_t         wcfg;

  assign wcfg = evt_cfg_t'(cfg_wdata_i);

  evt_cfg_reg u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .wdata_i (cfg_wdata_i),
    .cfg_o   (cfg),
    .wr_o    (wr)
  );

  evt_src_sel #(.CNT_W(CNT_W), .HAS_VIRT(HAS_VIRT)) u_src (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .phys_i (phys_cnt_i),
    .off_i  (virt_off_i),
    .virt_i (src_virt_i),
    .cnt_o  (cnt),
    .chg_o  (src_chg)
  );

  evt_edge_det #(.CNT_W(CNT_W)) u_det (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cnt_i     (cnt),
    .cfg_i     (cfg),
    .wr_i      (wr),
    .wr_idx_i  (wcfg.idx),
    .src_chg_i (src_chg),
    .evt_o     (evt_o)
  );

  p_reset_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> !evt_o);
endmodule

// File: tb/sim_evt_stream_gen.sv
module sim_evt_stream_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] phys = '0;
  logic [63:0] off = '0;
  logic        srcv = 1'b0;
  logic        we = 1'b0;
  logic [5:0]  wdata = '0;
  logic        evt_o;

  int checks = 0, failures = 0, n_evt = 0, cyc = 0;
  logic [63:0] step_amt = 64'd1;
  bit done = 0;

  // reference model state
  bit       m_en = 0, m_dir = 0, m_prev = 0, m_src = 0, m_exp = 0;
  int       m_idx = 0;

  always #5 clk = ~clk;

  evt_stream_gen u0 (
    .clk_i(clk), .rst_ni(rst_n), .phys_cnt_i(phys), .virt_off_i(off),
    .src_virt_i(srcv), .cfg_we_i(we), .cfg_wdata_i(wdata), .evt_o(evt_o)
  );

  task automatic chk(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s cycle %0d: evt_o=%b expected %b", tag, cyc, act, exp);
    end
  endtask

  task automatic chk_n(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s: pulse count=%0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic tick(input string tag);
    logic [63:0] c;
    bit cur, ld, nexp;
    @(posedge clk);
    cyc++;
    c    = srcv ? phys - off : phys;
    cur  = c[m_idx];
    ld   = c[int'(wdata[4:1])];
    nexp = m_en && !we && (srcv == m_src) && (m_prev != cur) && (cur != m_dir);
    m_prev = we ? ld : cur;
    if (we) begin
      m_en = wdata[0]; m_idx = int'(wdata[4:1]); m_dir = wdata[5];
    end
    m_src = srcv;
    m_exp = nexp;
    @(negedge clk);
    chk(evt_o, m_exp, tag);
    if (evt_o) n_evt++;
    phys = phys + step_amt;
    we = 1'b0;
  endtask

  task automatic wr(input bit en, input int idx, input bit dir, input string tag);
    wdata = {dir, 4'(idx), en};
    we = 1'b1;
    tick(tag);
  endtask

  task automatic run(input int n, input string tag);
    for (int i = 0; i < n; i++) tick(tag);
  endtask

  initial begin
    #1;
    @(negedge clk);
    chk(evt_o, 1'b0, "R1");
    @(negedge clk);
    rst_n = 1'b1;
    run(1, "R1");
    chk(evt_o, 1'b0, "R1");
    run(8, "R2");                          // reset state disabled

    // R3: rising on bit 0
    wr(1, 0, 0, "R7"); n_evt = 0;
    run(20, "R3");
    chk_n(n_evt, 10, "R3");

    // R4: falling on bit 2
    wr(1, 2, 1, "R7"); n_evt = 0;
    run(32, "R4");
    chk_n(n_evt, 4, "R4");

    // R5: bit 3 period of 16, R10 latency checked per cycle
    wr(1, 3, 0, "R7"); n_evt = 0;
    run(64, "R5");
    chk_n(n_evt, 4, "R5");

    // R2: disabled
    wr(0, 0, 0, "R7"); n_evt = 0;
    run(40, "R2");
    chk_n(n_evt, 0, "R2");

    // R7: write in the cycle the bit would rise
    wr(1, 0, 0, "R7");
    if (phys[0] == 1'b0) run(1, "R3");     // next sample odd -> rising
    wr(1, 0, 0, "R7");
    chk(evt_o, 1'b0, "R7");

    // R6: virtual source with offset
    off = 64'd5;
    srcv = 1'b1; run(1, "R8");
    wr(1, 1, 0, "R7"); n_evt = 0;
    run(32, "R6");
    chk_n(n_evt, 8, "R6");
    off = 64'd1003; run(12, "R6");

    // R8: toggling source, count frozen, sources differ in bit 0
    step_amt = 64'd0; off = 64'd1;
    wr(1, 0, 0, "R7"); n_evt = 0;
    for (int i = 0; i < 12; i++) begin
      srcv = ~srcv;
      tick("R8");
    end
    chk_n(n_evt, 0, "R8");

    // R9: jumps
    srcv = 1'b0; step_amt = 64'd16;
    wr(1, 3, 0, "R7"); n_evt = 0;
    run(20, "R9");
    chk_n(n_evt, 0, "R9");
    step_amt = 64'd24;
    wr(1, 3, 0, "R7"); n_evt = 0;
    run(20, "R9");
    chk_n(n_evt, 10, "R9");
    step_amt = 64'h1_0000;
    wr(1, 15, 1, "R7"); n_evt = 0;
    run(16, "R9");
    chk_n(n_evt, 0, "R9");
    step_amt = 64'h8000;
    wr(1, 15, 1, "R7"); n_evt = 0;
    run(16, "R9");
    chk_n(n_evt, 8, "R9");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: run did not complete, expected finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule